// File: doc/BRIEF.md
# Serial Configuration ROM Image Loader

This block copies a 64-word by 16-bit serial configuration ROM into an on-chip byte image as soon as reset is released. It drives the ROM over a three-wire serial link made of a select line, a bit clock and a command line, and it reads the reply on a fourth line. For each word it asserts select and sends a three-bit read opcode and the word address. It then shifts in the sixteen data bits and releases select before it starts the next word.

The words are stored little-endian in a 128-byte image. Once the image is complete, the block decides whether a ROM is fitted by looking at the first two bytes. It also takes a 48-bit station address from a fixed window of six bytes in the image. A one-cycle done pulse marks completion. The absent flag and the station address then hold their values until the next reset. The rest of the chip reads any image byte through a combinational read port. The length of each serial clock phase is set by an input, and a zero on that input selects a built-in default.

Top module: `srom_image_loader`

## Requirements
- R1: The load starts by itself after reset is released. `busy` is high from the second cycle after release until the load ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R2: Words are read in address order 0 to 63, so `srom_cs` rises exactly 64 times in a load. After each rise of `srom_cs`, the first nine bits on `srom_mosi` are the opcode 1,1,0 followed by the six-bit word address, most significant bit first. `srom_cs` returns low between words.
- R3: Each serial bit takes three phases: clock low, clock high, clock low. `srom_mosi` does not change during the high phase or during the low phases on either side of it. `srom_clk` is high only while `srom_cs` is high, and `srom_cs` never falls while `srom_clk` is high.
- R4: Every phase lasts `phase_len` clock cycles. A `phase_len` of 0 selects the default of 4 cycles.
- R5: After the nine command bits, sixteen data bits are taken from `srom_miso`, most significant bit first. Each bit is sampled on the last cycle of its clock-high phase.
- R6: Word w is stored with its bits 7:0 at image byte 2w and its bits 15:8 at image byte 2w+1. `rd_data` shows image byte `rd_addr` in the same cycle.
- R7: `absent` is set with `done` when image bytes 0 and 1 are both 8'hFF or both 8'h00, and is clear otherwise. `absent` and `station_addr` keep their values after `done`, and the serial lines stay idle, until the next reset.
- R8: When the ROM is present, `station_addr` is set with `done` to image bytes 20 to 25, with byte 20 in bits 47:40 and byte 25 in bits 7:0. When `absent` is set, `station_addr` is zero.
- R9: While reset is low, all serial outputs, `busy`, `done`, `absent` and `station_addr` are low and every image byte reads 0. This holds even when reset arrives in the middle of a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_len | input | 8 | Cycles per serial clock phase (0 = default 4) |
| srom_miso | input | 1 | Data bit returned by the ROM |
| srom_cs | output | 1 | ROM select |
| srom_clk | output | 1 | ROM bit clock |
| srom_mosi | output | 1 | Command bit sent to the ROM |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| absent | output | 1 | No ROM detected |
| station_addr | output | 48 | Station address taken from the image |
| rd_addr | input | 7 | Image byte address for the read port |
| rd_data | output | 8 | Image byte at `rd_addr` |

## Verification
Some rules are checked by assertions on every cycle: the serial framing rules, the handshake between `busy` and `done`, and the zero station address when `absent` is set. The framing rules are that the bit clock runs only under select, that select never drops with the clock high, and that the command line holds steady around each clock pulse. Other behaviour shows only in the bench's scenarios, where a behavioural ROM model answers the block: the opcode and address order seen by the ROM, the measured phase lengths for several `phase_len` settings including the default, and the byte order of the stored image. The same applies to both kinds of blank ROM, a ROM whose first two bytes differ, and the clearing of the image when reset arrives mid-load.

// File: rtl/srom_loader_pkg.sv
// Shared types for the serial ROM image loader.
// Assumes a read opcode of three bits sent before the word address.
package srom_loader_pkg;

    localparam int          OP_W    = 3;
    localparam logic [2:0]  READ_OP = 3'b110;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_SEL,
        ST_SHIFT,
        ST_DESEL,
        ST_FIN
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_LEAD,
        PH_HIGH,
        PH_TRAIL
    } bit_phase_t;

endpackage

// File: rtl/srom_phase_timer.sv
// Phase timer: raises tick on the last cycle of every serial clock phase.
// Assumes run stays high for the whole time the sequencer is framing bits;
// a phase_len of zero selects DEF_PHASE.
module srom_phase_timer #(
    parameter int DIV_W     = 8,
    parameter int DEF_PHASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] phase_len,
    output logic             tick
);

    logic [DIV_W-1:0] eff_len;
    logic [DIV_W-1:0] cnt;

    // Choose the active phase length.
    assign eff_len = (phase_len == '0) ? DIV_W'(DEF_PHASE) : phase_len;
    // Last cycle of the phase; >= guards against a shrinking length.
    assign tick    = run && (cnt >= eff_len - 1'b1);

    // Count cycles within the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/srom_serial_seq.sv
// Serial sequencer: frames one read per word (select, opcode, address,
// sixteen data bits, deselect) for every word in order, and hands each
// finished word to the image store. Assumes WORDS is a power of two.
module srom_serial_seq
    import srom_loader_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick,
    input  logic                     srom_miso,
    output logic                     run,
    output logic                     srom_cs,
    output logic                     srom_clk,
    output logic                     srom_mosi,
    output logic                     busy,
    output logic                     word_wr,
    output logic [$clog2(WORDS)-1:0] word_addr,
    output logic [WORD_W-1:0]        word_data,
    output logic                     fin
);

    localparam int ADDR_W     = $clog2(WORDS);
    localparam int CMD_W      = OP_W + ADDR_W;
    localparam int TOTAL_BITS = CMD_W + WORD_W;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 1);
    localparam logic [CNT_W-1:0]  FIRST_DATA = CNT_W'(CMD_W);
    localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(TOTAL_BITS - 1);
    localparam logic [ADDR_W-1:0] LAST_WORD  = ADDR_W'(WORDS - 1);

    seq_state_t        state;
    bit_phase_t        phase;
    logic [ADDR_W-1:0] word_idx;
    logic [CNT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] shreg;

    // Command bit b of the read frame for address a (zero past the command).
    function automatic logic cmd_bit(input logic [CNT_W-1:0] b,
                                     input logic [ADDR_W-1:0] a);
        logic [CMD_W-1:0] w;
        w = {READ_OP, a};
        if (int'(b) < CMD_W) return w[CMD_W - 1 - int'(b)];
        return 1'b0;
    endfunction

    // Phase timer runs whenever a frame is being timed.
    assign run = (state == ST_SEL) || (state == ST_SHIFT) || (state == ST_DESEL);

    // Walk the word frames and drive the serial lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_INIT;
            phase     <= PH_LEAD;
            word_idx  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            srom_cs   <= 1'b0;
            srom_clk  <= 1'b0;
            srom_mosi <= 1'b0;
            busy      <= 1'b0;
            word_wr   <= 1'b0;
            word_addr <= '0;
            word_data <= '0;
            fin       <= 1'b0;
        end else begin
            word_wr <= 1'b0;
            fin     <= 1'b0;
            case (state)
                ST_INIT: begin
                    state   <= ST_SEL;
                    srom_cs <= 1'b1;
                    busy    <= 1'b1;
                end
                ST_SEL: if (tick) begin
                    state     <= ST_SHIFT;
                    phase     <= PH_LEAD;
                    bit_idx   <= '0;
                    srom_mosi <= cmd_bit('0, word_idx);
                end
                ST_SHIFT: if (tick) begin
                    case (phase)
                        PH_LEAD: begin
                            phase    <= PH_HIGH;
                            srom_clk <= 1'b1;
                        end
                        PH_HIGH: begin
                            phase    <= PH_TRAIL;
                            srom_clk <= 1'b0;
                            if (bit_idx >= FIRST_DATA)
                                shreg <= {shreg[WORD_W-2:0], srom_miso};
                        end
                        default: begin
                            if (bit_idx == LAST_BIT) begin
                                state     <= ST_DESEL;
                                srom_cs   <= 1'b0;
                                srom_mosi <= 1'b0;
                                word_wr   <= 1'b1;
                                word_addr <= word_idx;
                                word_data <= shreg;
                            end else begin
                                phase     <= PH_LEAD;
                                bit_idx   <= bit_idx + 1'b1;
                                srom_mosi <= cmd_bit(bit_idx + 1'b1, word_idx);
                            end
                        end
                    endcase
                end
                ST_DESEL: if (tick) begin
                    if (word_idx == LAST_WORD) begin
                        state <= ST_FIN;
                        busy  <= 1'b0;
                        fin   <= 1'b1;
                    end else begin
                        state    <= ST_SEL;
                        word_idx <= word_idx + 1'b1;
                        srom_cs  <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/srom_image_store.sv
// Image store: keeps the byte image little-endian, serves the read port,
// and on the final-word strobe decides absence and latches the station
// address. Assumes fin arrives after the last word has been written.
module srom_image_store #(
    parameter int WORDS     = 64,
    parameter int WORD_W    = 16,
    parameter int MAC_OFS   = 20,
    parameter int MAC_BYTES = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           word_wr,
    input  logic [$clog2(WORDS)-1:0]       word_addr,
    input  logic [WORD_W-1:0]              word_data,
    input  logic                           fin,
    input  logic [$clog2(WORDS*2)-1:0]     rd_addr,
    output logic [7:0]                     rd_data,
    output logic                           done,
    output logic                           absent,
    output logic [8*MAC_BYTES-1:0]         station_addr
);

    localparam int BYTES = WORDS * 2;

    logic [7:0]             img [BYTES];
    logic [8*MAC_BYTES-1:0] mac_cat;
    logic                   blank;

    // Gather the station address bytes, first byte most significant.
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
        assign mac_cat[8*(MAC_BYTES-1-g) +: 8] = img[MAC_OFS + g];
    end

    // Blank ROM: first two bytes both all-ones or both all-zeros.
    assign blank   = ((img[0] == 8'hFF) && (img[1] == 8'hFF)) ||
                     ((img[0] == 8'h00) && (img[1] == 8'h00));
    // Combinational read port.
    assign rd_data = img[rd_addr];

    // Store words and latch the results at the end of the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) img[i] <= 8'h00;
            done         <= 1'b0;
            absent       <= 1'b0;
            station_addr <= '0;
        end else begin
            done <= fin;
            if (word_wr) begin
                img[{word_addr, 1'b0}] <= word_data[7:0];
                img[{word_addr, 1'b1}] <= word_data[15:8];
            end
            if (fin) begin
                absent       <= blank;
                station_addr <= blank ? '0 : mac_cat;
            end
        end
    end

endmodule

// File: rtl/srom_image_loader.sv
// Top: loads the serial configuration ROM into an on-chip image after
// reset and reports absence and the station address. Assumes the ROM
// answers each read with sixteen bits while select stays high.
module srom_image_loader #(
    parameter  int WORDS     = 64,
    parameter  int DIV_W     = 8,
    parameter  int DEF_PHASE = 4,
    parameter  int MAC_OFS   = 20,
    localparam int MAC_BYTES = 6,
    localparam int BA_W      = $clog2(WORDS * 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIV_W-1:0]       phase_len,
    input  logic                   srom_miso,
    output logic                   srom_cs,
    output logic                   srom_clk,
    output logic                   srom_mosi,
    output logic                   busy,
    output logic                   done,
    output logic                   absent,
    output logic [8*MAC_BYTES-1:0] station_addr,
    input  logic [BA_W-1:0]        rd_addr,
    output logic [7:0]             rd_data
);

    localparam int WORD_W = 16;
    localparam int ADDR_W = $clog2(WORDS);

    logic              run;
    logic              tick;
    logic              seq_busy;
    logic              word_wr;
    logic [ADDR_W-1:0] word_addr;
    logic [WORD_W-1:0] word_data;
    logic              fin;

    // Busy covers the final strobe so done follows busy directly.
    assign busy = seq_busy | fin;

    srom_phase_timer #(.DIV_W(DIV_W), .DEF_PHASE(DEF_PHASE)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .phase_len(phase_len), .tick(tick)
    );

    srom_serial_seq #(.WORDS(WORDS), .WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .srom_miso(srom_miso),
        .run(run), .srom_cs(srom_cs), .srom_clk(srom_clk),
        .srom_mosi(srom_mosi), .busy(seq_busy), .word_wr(word_wr),
        .word_addr(word_addr), .word_data(word_data), .fin(fin)
    );

    srom_image_store #(.WORDS(WORDS), .WORD_W(WORD_W), .MAC_OFS(MAC_OFS),
                       .MAC_BYTES(MAC_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .word_wr(word_wr), .word_addr(word_addr),
        .word_data(word_data), .fin(fin), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .absent(absent),
        .station_addr(station_addr)
    );

endmodule

// File: rtl/srom_loader_checker.sv
// Protocol and handshake checker for the serial ROM image loader.
// Assumes it is attached to the top module through the bind below.
module srom_loader_checker #(
    parameter int ST_W = 48
) (
    input logic            clk,
    input logic            rst_n,
    input logic            srom_cs,
    input logic            srom_clk,
    input logic            srom_mosi,
    input logic            busy,
    input logic            done,
    input logic            absent,
    input logic [ST_W-1:0] station_addr
);

    AST_CLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        srom_clk |-> srom_cs); // R3

    AST_CS_DROP_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(srom_cs) |-> !srom_clk); // R3

    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (srom_clk || $past(srom_clk)) |-> $stable(srom_mosi)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R1

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R1

    AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $past(srom_cs == 1'b0)) |-> !srom_cs); // R7

    AST_ABSENT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        absent |-> (station_addr == '0)); // R8

endmodule

bind srom_image_loader srom_loader_checker #(.ST_W(48)) u_chk (
    .clk(clk), .rst_n(rst_n), .srom_cs(srom_cs), .srom_clk(srom_clk),
    .srom_mosi(srom_mosi), .busy(busy), .done(done), .absent(absent),
    .station_addr(station_addr)
);

// File: tb/srom_image_loader_bench.sv
module srom_image_loader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCASE      = 5;
    // {phase_len[32:25], rom mode[24:17], expected absent[16], seed[15:0]}
    // rom mode: 0 word0=seed, 1 word0=FFFF, 2 word0=0000, 3 word0=00FF
    localparam logic [32:0] CASES [NCASE] = '{
        {8'd0, 8'd0, 1'b0, 16'hA5C3},
        {8'd1, 8'd1, 1'b1, 16'h3C5A},
        {8'd2, 8'd2, 1'b1, 16'h7E81},
        {8'd3, 8'd3, 1'b0, 16'h1234},
        {8'd1, 8'd0, 1'b0, 16'hF00D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  phase_len = 8'd0;
    logic        srom_miso = 1'b0;
    logic        srom_cs, srom_clk, srom_mosi, busy, done, absent;
    logic [47:0] station_addr;
    logic [6:0]  rd_addr = 7'd0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // ROM model and monitor state
    logic [15:0] rom_seed = 16'h0;
    int          rom_mode = 0;
    int          rom_bit = 0;
    logic [8:0]  rom_cmd = 9'h0;
    int          cs_rises = 0;
    int          cmd_errs = 0;
    int          exp_word = 0;
    logic        mosi_at_rise = 1'b0;
    int          mosi_errs = 0;
    int          hi_run = 0;
    int          hi_cnt = 0;
    int          hi_errs = 0;
    int          exp_hi = 4;

    srom_image_loader u_srom_image_loader (
        .clk(clk), .rst_n(rst_n), .phase_len(phase_len), .srom_miso(srom_miso),
        .srom_cs(srom_cs), .srom_clk(srom_clk), .srom_mosi(srom_mosi),
        .busy(busy), .done(done), .absent(absent), .station_addr(station_addr),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [15:0] rom_word(input logic [15:0] seed,
                                             input int mode, input int a);
        if (a == 0) begin
            case (mode)
                1: return 16'hFFFF;
                2: return 16'h0000;
                3: return 16'h00FF;
                default: return seed;
            endcase
        end
        return 16'(a * 40503) ^ seed ^ 16'(a << 8);
    endfunction

    function automatic logic [7:0] img_byte(input logic [15:0] seed,
                                            input int mode, input int i);
        logic [15:0] w;
        w = rom_word(seed, mode, i / 2);
        return (i % 2 == 1) ? w[15:8] : w[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ROM model: new frame on select rise
    always @(posedge srom_cs) begin
        rom_bit = 0;
        rom_cmd = 9'h0;
        cs_rises++;
    end

    // ROM model: capture command bits, present data bits on clock rise
    always @(posedge srom_clk) begin
        logic [15:0] w;
        mosi_at_rise = srom_mosi;
        if (rom_bit < 9) begin
            rom_cmd = {rom_cmd[7:0], srom_mosi};
            if (rom_bit == 8) begin
                if (rom_cmd[8:6] != 3'b110 || rom_cmd[5:0] != 6'(exp_word))
                    cmd_errs++;
                exp_word++;
            end
        end else if (rom_bit < 25) begin
            w = rom_word(rom_seed, rom_mode, int'(rom_cmd[5:0]));
            srom_miso = w[15 - (rom_bit - 9)];
        end
        rom_bit++;
    end

    always @(negedge srom_clk) if (srom_mosi !== mosi_at_rise) mosi_errs++;

    // Measure clock-high phase lengths
    always @(negedge clk) begin
        if (srom_clk === 1'b1) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run != exp_hi) hi_errs++;
            hi_cnt++;
            hi_run = 0;
        end
    end

    task automatic clear_monitors();
        cs_rises = 0; cmd_errs = 0; exp_word = 0; mosi_errs = 0;
        hi_run = 0; hi_cnt = 0; hi_errs = 0;
    endtask

    task automatic run_case(input logic [32:0] c);
        logic [7:0]  plen;
        int          mode;
        bit          exp_abs;
        logic [47:0] exp_st;
        logic [47:0] held_st;
        bit          held_abs;
        bit          pb;
        int          n;
        int          bad;
        plen = c[32:25]; mode = int'(c[24:17]); exp_abs = c[16];
        rst_n = 1'b0;
        phase_len = plen;
        rom_seed = c[15:0];
        rom_mode = mode;
        exp_hi = (plen == 8'd0) ? 4 : int'(plen);
        repeat (3) @(negedge clk);
        clear_monitors();
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R1", "busy during load", busy, 1);
        n = 0;
        pb = busy;
        forever begin
            @(negedge clk);
            if (done || n > 100000) break;
            pb = busy;
            n++;
        end
        check(done && !busy && pb, "R1", "done in first cycle after busy",
              {done, busy, pb}, 3'b101);
        // R8 / R7 expected results
        exp_st = '0;
        if (!exp_abs)
            for (int k = 0; k < 6; k++)
                exp_st = {exp_st[39:0], img_byte(rom_seed, mode, 20 + k)};
        check(absent == exp_abs, "R7", "absent flag", absent, exp_abs);
        check(station_addr == exp_st, "R8", "station address", station_addr, exp_st);
        @(negedge clk);
        check(!done, "R1", "done width one cycle", done, 0);
        check(cs_rises == 64, "R2", "select rises", cs_rises, 64);
        check(cmd_errs == 0 && exp_word == 64, "R2", "opcode/address errors",
              cmd_errs, 0);
        check(mosi_errs == 0, "R3", "mosi moved around clock pulse", mosi_errs, 0);
        check(hi_errs == 0 && hi_cnt == 64 * 25, "R4", "phase length errors",
              hi_errs, 0);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            rd_addr = 7'(i);
            #1;
            if (rd_data != img_byte(rom_seed, mode, i)) bad++;
        end
        check(bad == 0, "R5 R6", "image byte mismatches", bad, 0);
        held_st = station_addr;
        held_abs = absent;
        repeat (40) @(negedge clk);
        check(absent == held_abs && station_addr == held_st && !srom_cs && !busy,
              "R7", "results held and lines idle", {absent, srom_cs, busy},
              {held_abs, 2'b00});
    endtask

    // Watchdog
    initial begin
        wait (cyc >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        rd_addr = 7'd5;
        #1;
        check(!srom_cs && !srom_clk && !srom_mosi, "R9", "serial lines in reset",
              {srom_cs, srom_clk, srom_mosi}, 0);
        check(!busy && !done, "R9", "busy/done in reset", {busy, done}, 0);
        check(!absent && station_addr == '0, "R9", "results in reset",
              station_addr, 0);
        check(rd_data == 8'h00, "R9", "image byte in reset", rd_data, 0);

        // table-driven loads
        for (int t = 0; t < NCASE; t++) run_case(CASES[t]);

        // R9: reset in the middle of a load clears image and lines
        rst_n = 1'b0;
        phase_len = 8'd1;
        rom_seed = 16'hBEEF;
        rom_mode = 0;
        exp_hi = 1;
        repeat (2) @(negedge clk);
        clear_monitors();
        rst_n = 1'b1;
        repeat (500) @(negedge clk);
        rd_addr = 7'd0;
        #1;
        check(rd_data == 8'hEF, "R6", "word 0 low byte mid-load", rd_data, 8'hEF);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(!srom_cs && !busy && !srom_clk, "R9", "lines after mid-load reset",
              {srom_cs, busy, srom_clk}, 0);
        check(rd_data == 8'h00, "R9", "image cleared by reset", rd_data, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule